// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block drives one open-drain, single-wire bus on behalf of a controller that wants one bus operation at a time. It has three commands: a bus reset with detection of a responding device, a one-bit write, and a one-bit read. A divider turns the system clock into microsecond ticks, and every phase of every operation is timed in whole microseconds. The block drives the bus through a pull-low enable, and it observes the bus through a synchronized input. The pull-up resistor sits outside the block.

A caller places a command on the command inputs with `cmd_valid` while `busy` is low. The engine then runs the whole waveform, including a released recovery gap after each bit slot. At the end it raises `done` for one clock. It keeps the presence result and the last read bit on registered outputs. Higher layers such as byte assembly, addressing and checksums sit above this engine. The engine also holds an optional strong pull-up enable output. It copies this enable from its request input only while idle, so the enable cannot change during an operation.

Top module: `slot_master`

## Requirements
- R1: A reset command pulls the bus low for exactly T_RST_LOW (480) µs from acceptance, then releases it.
- R2: `presence` is set to 1 when the synchronized bus is low at T_PRES_SAMPLE (70) µs after the reset release, and to 0 otherwise. The reset operation completes T_PRES_SAMPLE+T_RST_TAIL (480) µs after release. `presence` keeps its value until the next reset.
- R3: A write with `cmd_wbit`=1 pulls the bus low for exactly T_W1_LOW (6) µs. The bus is high when a device samples it 30 µs into the slot.
- R4: A write with `cmd_wbit`=0 pulls the bus low for exactly T_W0_LOW (60) µs. The bus is low 30 µs into the slot.
- R5: A read pulls the bus low for exactly T_RD_LOW (2) µs. `rd_bit` takes the synchronized bus level (1 = high) sampled T_RD_SAMPLE (13) µs after the slot starts.
- R6: A write or read completes T_SLOT+T_REC (65) µs after acceptance. The bus is released for at least T_REC µs before any later pull-low.
- R7: A command presented while `busy` is high has no effect, including one presented on the clock edge where the current operation completes.
- R8: `busy` rises on the clock after acceptance. `done` is a single-cycle pulse, and `busy` is low in that same cycle.
- R9: Command encoding on `cmd_op`: 2'b01 is reset, 2'b10 is write (the bit comes from `cmd_wbit`), 2'b11 is read, and 2'b00 is no operation, which is ignored.
- R10: `spu_en` follows `spu_req` with one clock of delay while idle and stays constant while `busy` is high.
- R11: After reset, `busy`, `done`, `bus_pull_low`, `presence`, `rd_bit` and `spu_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, honoured only when idle |
| cmd_op | input | 2 | Operation code (see R9) |
| cmd_wbit | input | 1 | Bit value for a write |
| spu_req | input | 1 | Strong pull-up request, captured while idle |
| bus_in | input | 1 | Observed bus level (asynchronous) |
| bus_pull_low | output | 1 | 1 pulls the bus low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A device answered the last reset |
| rd_bit | output | 1 | Bit captured by the last read |
| spu_en | output | 1 | Strong pull-up enable |

## Verification
The sensitive coincidence is a new command that arrives on the very edge where the recovery phase finishes and `done` is raised. The engine is still busy on that edge, so the command must be dropped rather than start a second slot. The bench places a write-0 request on exactly that edge. It then checks that only one `done` occurred and that the bus stays released afterwards. A second collision puts a command in the middle of a read slot. There the bench judges the pull-low length and the captured bit.

// File: rtl/slot_pkg.sv
package slot_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } slot_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_LISTEN,
    ST_SLOT,
    ST_RECOVER
  } slot_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = (div_q == LAST) && !restart;
endmodule

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_pkg::*;
#(
  parameter int T_RST_LOW     = 480,
  parameter int T_PRES_SAMPLE = 70,
  parameter int T_RST_TAIL    = 410,
  parameter int T_W1_LOW      = 6,
  parameter int T_W0_LOW      = 60,
  parameter int T_RD_LOW      = 2,
  parameter int T_RD_SAMPLE   = 13,
  parameter int T_SLOT        = 60,
  parameter int T_REC         = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       spu_req,
  input  logic       tick,
  input  logic       line_s,
  output logic       tick_restart,
  output logic       pull_low,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       spu_en
);
  localparam int MAX_US = max2(max2(T_RST_LOW, T_PRES_SAMPLE + T_RST_TAIL),
                               max2(T_SLOT, T_REC));
  localparam int USW = $clog2(MAX_US + 1);

  localparam logic [USW-1:0] K_RST_END  = USW'(T_RST_LOW - 1);
  localparam logic [USW-1:0] K_PRES_AT  = USW'(T_PRES_SAMPLE - 1);
  localparam logic [USW-1:0] K_LIS_END  = USW'(T_PRES_SAMPLE + T_RST_TAIL - 1);
  localparam logic [USW-1:0] K_W1_END   = USW'(T_W1_LOW - 1);
  localparam logic [USW-1:0] K_W0_END   = USW'(T_W0_LOW - 1);
  localparam logic [USW-1:0] K_RD_END   = USW'(T_RD_LOW - 1);
  localparam logic [USW-1:0] K_RD_AT    = USW'(T_RD_SAMPLE - 1);
  localparam logic [USW-1:0] K_SLOT_END = USW'(T_SLOT - 1);
  localparam logic [USW-1:0] K_REC_END  = USW'(T_REC - 1);

  slot_state_e    state_q;
  logic [USW-1:0] us_q;
  logic [USW-1:0] low_end_q;
  logic           is_read_q;
  slot_op_e       op_in;
  logic           accept;

  assign op_in        = slot_op_e'(cmd_op);
  assign accept       = (state_q == ST_IDLE) && cmd_valid && (op_in != OP_NONE);
  assign tick_restart = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      us_q      <= '0;
      low_end_q <= '0;
      is_read_q <= 1'b0;
      pull_low  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
      spu_en    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          spu_en <= spu_req;
          if (accept) begin
            busy     <= 1'b1;
            pull_low <= 1'b1;
            us_q     <= '0;
            unique case (op_in)
              OP_RESET: begin
                state_q   <= ST_RST_LOW;
                is_read_q <= 1'b0;
              end
              OP_WRITE: begin
                state_q   <= ST_SLOT;
                is_read_q <= 1'b0;
                low_end_q <= cmd_wbit ? K_W1_END : K_W0_END;
              end
              default: begin
                state_q   <= ST_SLOT;
                is_read_q <= 1'b1;
                low_end_q <= K_RD_END;
              end
            endcase
          end
        end

        ST_RST_LOW: begin
          if (tick) begin
            if (us_q == K_RST_END) begin
              pull_low <= 1'b0;
              us_q     <= '0;
              state_q  <= ST_RST_LISTEN;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end

        ST_RST_LISTEN: begin
          if (tick) begin
            if (us_q == K_PRES_AT) begin
              presence <= ~line_s;
            end
            if (us_q == K_LIS_END) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              us_q    <= '0;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end

        ST_SLOT: begin
          if (tick) begin
            if (us_q == low_end_q) begin
              pull_low <= 1'b0;
            end
            if (is_read_q && (us_q == K_RD_AT)) begin
              rd_bit <= line_s;
            end
            if (us_q == K_SLOT_END) begin
              state_q <= ST_RECOVER;
              us_q    <= '0;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end

        ST_RECOVER: begin
          if (tick) begin
            if (us_q == K_REC_END) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              us_q    <= '0;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end

        default: begin
          state_q  <= ST_IDLE;
          busy     <= 1'b0;
          pull_low <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/slot_master.sv
module slot_master #(
  parameter int CLK_PER_US    = 125,
  parameter int SYNC_STAGES   = 2,
  parameter int T_RST_LOW     = 480,
  parameter int T_PRES_SAMPLE = 70,
  parameter int T_RST_TAIL    = 410,
  parameter int T_W1_LOW      = 6,
  parameter int T_W0_LOW      = 60,
  parameter int T_RD_LOW      = 2,
  parameter int T_RD_SAMPLE   = 13,
  parameter int T_SLOT        = 60,
  parameter int T_REC         = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       spu_req,
  input  logic       bus_in,
  output logic       bus_pull_low,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       spu_en
);
  logic tick;
  logic tick_restart;
  logic line_s;

  us_tick_gen #(
    .CLK_PER_US(CLK_PER_US)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .restart(tick_restart),
    .tick   (tick)
  );

  bus_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (bus_in),
    .dout(line_s)
  );

  slot_sequencer #(
    .T_RST_LOW    (T_RST_LOW),
    .T_PRES_SAMPLE(T_PRES_SAMPLE),
    .T_RST_TAIL   (T_RST_TAIL),
    .T_W1_LOW     (T_W1_LOW),
    .T_W0_LOW     (T_W0_LOW),
    .T_RD_LOW     (T_RD_LOW),
    .T_RD_SAMPLE  (T_RD_SAMPLE),
    .T_SLOT       (T_SLOT),
    .T_REC        (T_REC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wbit    (cmd_wbit),
    .spu_req     (spu_req),
    .tick        (tick),
    .line_s      (line_s),
    .tick_restart(tick_restart),
    .pull_low    (bus_pull_low),
    .busy        (busy),
    .done        (done),
    .presence    (presence),
    .rd_bit      (rd_bit),
    .spu_en      (spu_en)
  );
endmodule

// File: rtl/slot_master_chk.sv
module slot_master_chk #(
  parameter int CLK_PER_US = 125,
  parameter int T_RST_LOW  = 480,
  parameter int T_W1_LOW   = 6,
  parameter int T_W0_LOW   = 60,
  parameter int T_RD_LOW   = 2,
  parameter int T_REC      = 5
) (
  input logic clk,
  input logic rst,
  input logic pull_low,
  input logic busy,
  input logic done,
  input logic spu_en
);
  localparam int GAP_MIN = T_REC * CLK_PER_US;

  logic [31:0] low_run;
  logic [31:0] gap_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      gap_run <= 32'(GAP_MIN);
    end else begin
      low_run <= pull_low ? low_run + 1 : '0;
      if (pull_low)               gap_run <= '0;
      else if (gap_run < GAP_MIN) gap_run <= gap_run + 1;
    end
  end

  // R1 R3 R4 R5: every low pulse has one of the four legal lengths
  a_r1_low_length: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_low) |-> (low_run == 32'(T_RST_LOW * CLK_PER_US) ||
                         low_run == 32'(T_W0_LOW * CLK_PER_US) ||
                         low_run == 32'(T_W1_LOW * CLK_PER_US) ||
                         low_run == 32'(T_RD_LOW * CLK_PER_US)));

  a_r6_recovery_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low) |-> (gap_run >= 32'(GAP_MIN)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pull_low);

  a_r10_spu_static: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(spu_en));
endmodule

bind slot_master slot_master_chk #(
  .CLK_PER_US(CLK_PER_US),
  .T_RST_LOW (T_RST_LOW),
  .T_W1_LOW  (T_W1_LOW),
  .T_W0_LOW  (T_W0_LOW),
  .T_RD_LOW  (T_RD_LOW),
  .T_REC     (T_REC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pull_low(bus_pull_low),
  .busy    (busy),
  .done    (done),
  .spu_en  (spu_en)
);

// File: tb/sim_slot_master.sv
`timescale 1ns/1ps
module sim_slot_master;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_wbit = 1'b0;
  logic       spu_req = 1'b0;
  logic       dev_low = 1'b0;
  logic       bus_in;
  logic       bus_pull_low, busy, done, presence, rd_bit, spu_en;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign bus_in = !(bus_pull_low || dev_low);

  slot_master #(.CLK_PER_US(CPU)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .spu_req(spu_req), .bus_in(bus_in),
    .bus_pull_low(bus_pull_low), .busy(busy), .done(done),
    .presence(presence), .rd_bit(rd_bit), .spu_en(spu_en)
  );

  int r_low, r_done_cyc, r_done_cnt, r_line30, r_busy1, r_busy_done;
  int r_after_pull, r_after_busy, r_spu_moved;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one command; device pulls low during [ds, ds+dl) us from acceptance.
  task automatic run_op(input logic [1:0] op, input logic wb, input int ds,
                        input int dl, input int inj, input int spu_at);
    int cyc;
    int spu_ref;
    r_low = 0; r_done_cyc = 0; r_done_cnt = 0; r_line30 = -1;
    r_busy1 = 0; r_busy_done = 1; r_after_pull = 1; r_after_busy = 1;
    r_spu_moved = 0; spu_ref = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (cyc < 6000) begin
      if (cyc == 1) begin r_busy1 = busy; spu_ref = spu_en; end
      if (busy && (spu_en != spu_ref[0])) r_spu_moved = 1;
      if (bus_pull_low) r_low++;
      if (done) begin
        r_done_cnt++;
        if (r_done_cyc == 0) begin r_done_cyc = cyc; r_busy_done = busy; end
      end
      if (cyc == 30 * CPU) r_line30 = bus_in;
      if (r_done_cyc != 0 && cyc == r_done_cyc + 3) begin
        r_after_pull = bus_pull_low; r_after_busy = busy;
        break;
      end
      if (cyc == inj) begin
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_wbit = 1'b0;
      end else begin
        cmd_valid = 1'b0;
      end
      if (cyc == spu_at) spu_req = ~spu_req;
      dev_low = (dl > 0) && (cyc >= ds * CPU) && (cyc < (ds + dl) * CPU);
      @(negedge clk);
      cyc++;
    end
    dev_low = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(busy == 0, "R11 busy", busy, 0);
    chk(done == 0, "R11 done", done, 0);
    chk(bus_pull_low == 0, "R11 pull", bus_pull_low, 0);
    chk(presence == 0, "R11 presence", presence, 0);
    chk(rd_bit == 0, "R11 rd_bit", rd_bit, 0);
    chk(spu_en == 0, "R11 spu_en", spu_en, 0);
  endtask

  task automatic t_reset_cases();
    run_op(2'b01, 0, 0, 0, 0, 0);
    chk(r_low == 480 * CPU, "R1 reset low length", r_low, 480 * CPU);
    chk(presence == 0, "R2 no device -> no presence", presence, 0);
    run_op(2'b01, 0, 480 + 30, 120, 0, 0);
    chk(r_low == 480 * CPU, "R1 reset low length with device", r_low, 480 * CPU);
    chk(presence == 1, "R2 presence detected", presence, 1);
    chk(r_done_cyc == 960 * CPU + 1, "R2 reset completion time", r_done_cyc, 960 * CPU + 1);
    chk(r_busy1 == 1, "R8 busy after accept", r_busy1, 1);
  endtask

  task automatic t_writes();
    run_op(2'b10, 1, 0, 0, 65 * CPU, 0);
    chk(r_low == 6 * CPU, "R3 write1 low length", r_low, 6 * CPU);
    chk(r_line30 == 1, "R3 write1 bus high at 30us", r_line30, 1);
    chk(r_done_cyc == 65 * CPU + 1, "R6 write1 completion", r_done_cyc, 65 * CPU + 1);
    chk(r_done_cnt == 1, "R7 edge-collision single done", r_done_cnt, 1);
    chk(r_after_pull == 0 && r_after_busy == 0, "R7 edge-collision ignored",
        r_after_pull + r_after_busy, 0);
    chk(r_busy_done == 0, "R8 busy low at done", r_busy_done, 0);
    run_op(2'b10, 0, 0, 0, 0, 0);
    chk(r_low == 60 * CPU, "R4 write0 low length", r_low, 60 * CPU);
    chk(r_line30 == 0, "R4 write0 bus low at 30us", r_line30, 0);
    chk(r_done_cyc == 65 * CPU + 1, "R6 write0 completion", r_done_cyc, 65 * CPU + 1);
    chk(presence == 1, "R2 presence held across slots", presence, 1);
  endtask

  task automatic t_reads();
    run_op(2'b11, 0, 1, 30, 0, 0);
    chk(r_low == 2 * CPU, "R5 read low length", r_low, 2 * CPU);
    chk(rd_bit == 0, "R5 read 0", rd_bit, 0);
    run_op(2'b11, 0, 0, 0, 20, 0);
    chk(r_low == 2 * CPU, "R7 mid-slot command ignored (low length)", r_low, 2 * CPU);
    chk(rd_bit == 1, "R5 read 1", rd_bit, 1);
    chk(r_done_cnt == 1, "R7 mid-slot single done", r_done_cnt, 1);
    chk(r_done_cyc == 65 * CPU + 1, "R6 read completion", r_done_cyc, 65 * CPU + 1);
    // device releases before sample point -> reads 1
    run_op(2'b11, 0, 1, 8, 0, 0);
    chk(rd_bit == 1, "R5 late sample sees release", rd_bit, 1);
  endtask

  task automatic t_presence_windows();
    run_op(2'b01, 0, 480 + 15, 50, 0, 0);
    chk(presence == 0, "R2 pulse ended before sample", presence, 0);
    run_op(2'b01, 0, 480 + 75, 100, 0, 0);
    chk(presence == 0, "R2 pulse started after sample", presence, 0);
  endtask

  task automatic t_nop();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (busy || bus_pull_low) begin
        chk(0, "R9 no-op started activity", 1, 0);
      end
    end
    chk(busy == 0 && bus_pull_low == 0, "R9 no-op ignored", busy + bus_pull_low, 0);
  endtask

  task automatic t_spu();
    spu_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(spu_en == 1, "R10 spu follows while idle", spu_en, 1);
    run_op(2'b10, 1, 0, 0, 0, 10);
    chk(r_spu_moved == 0, "R10 spu stable while busy", r_spu_moved, 0);
    @(negedge clk);
    @(negedge clk);
    chk(spu_en == 0, "R10 spu updates after done", spu_en, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_reset_cases();
    t_writes();
    t_reads();
    t_nop();
    t_spu();
    t_presence_windows();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule